// File: doc/BRIEF.md
# ADC output word formatter

This block sits between a converter core and the device's parallel output pins. On each encode period it takes one raw conversion result in offset binary, along with over-range and under-range flags. It registers a formatted word, one overflow bit, a status bit for the clock duty-cycle stabilizer, and a complementary pair of output clocks. Downstream logic uses this clock pair to capture the word.

A 2-bit decoded mode level does two things. It picks offset-binary or two's-complement output, and it reports whether the duty-cycle stabilizer should run. An optional scrambler XORs every bit above the least significant bit with that final LSB. The LSB itself always passes through unscrambled, so a receiver can undo the scrambling.

The encode period lasts `DIV` cycles of the fast block clock. All inputs are sampled once per period, on its last cycle. The output clock goes low on the edge where new data appears and goes high again half a period later, in the middle of the stable data window.

Top module: `adc_word_fmt`

## Requirements
- R1: With mode level 0 or 1 and scrambling off, `dout` equals the sampled `raw_code` unchanged (offset binary).
- R2: With mode level 2 or 3, the word is two's complement: bit 15 of the sampled code is inverted before any scrambling, and the other bits are kept.
- R3: `dcs_en` is 1 for mode levels 1 and 2 and 0 for levels 0 and 3. It is registered with each word.
- R4: With `scramble_en` high, each bit 15..1 of `dout` equals the formatted bit XOR the formatted bit 0.
- R5: `dout[0]` always equals bit 0 of the sampled `raw_code`, whatever the mode and scramble setting.
- R6: `ovf` is the OR of `over_rng` and `under_rng`, sampled together with the word. It is never scrambled.
- R7: `clk_out_p` falls on the same edge as each word update and rises `DIV/2` cycles later. `clk_out_n` is always its complement.
- R8: Inputs are sampled only on the last cycle of each encode period. Changes at other times leave every output untouched until the next word.
- R9: While `rst_n` is low: `dout` = 0, `ovf` = 0, `dcs_en` = 0, `clk_out_p` = 1 and `clk_out_n` = 0.
- R10: A new word is registered every `DIV` cycles. The first word appears on the `DIV`-th rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, `DIV` cycles per encode period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| raw_code | input | 16 | Raw offset-binary conversion result |
| over_rng | input | 1 | Sample above full scale |
| under_rng | input | 1 | Sample below full scale |
| mode_lvl | input | 2 | Decoded mode level 0..3 |
| scramble_en | input | 1 | Scramble bits 15..1 with the LSB |
| dout | output | 16 | Formatted parallel data word |
| ovf | output | 1 | Overflow or underflow of the current word |
| dcs_en | output | 1 | Duty-cycle stabilizer enable for the current mode |
| clk_out_p | output | 1 | Output clock; data valid on its rising edge |
| clk_out_n | output | 1 | Inverted output clock |

## Verification
A phase counter that slips shows up within one encode period, because the clock edges drift against the data. A word then lands while `clk_out_p` is high, and the rise is no longer `DIV/2` cycles after the fall. A wrong format or scramble path gives a wrong `dout` on the very next word, and a corrupted LSB also breaks every scrambled bit of that word. Sampling inputs on the wrong cycle changes `dout` in the middle of a word. The bench changes its inputs every cycle, so this is seen within one period.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic [1:0] {
    MODE_OB_NOSTAB = 2'd0,
    MODE_OB_STAB   = 2'd1,
    MODE_TC_STAB   = 2'd2,
    MODE_TC_NOSTAB = 2'd3
  } fmt_mode_e;

  // Upper half of the level range selects two's complement
  function automatic logic mode_is_tc(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  // Stabilizer runs only for the two middle levels
  function automatic logic mode_stab(input logic [1:0] lvl);
    return (lvl == MODE_OB_STAB) || (lvl == MODE_TC_STAB);
  endfunction

endpackage

// File: rtl/adc_fmt_phase.sv
module adc_fmt_phase #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_o,
  output logic rise_o
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] MID  = PW'(HALF - 1);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    load_o = (ph_q == LAST);
    rise_o = (ph_q == MID);
    ph_d   = load_o ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  p_phase_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST);
  p_phase_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (ph_q == '0));

endmodule

// File: rtl/adc_fmt_encode.sv
module adc_fmt_encode #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw_i,
  input  logic         tc_i,
  input  logic         scr_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] fmt;

  always_comb begin
    fmt        = raw_i;
    fmt[W-1]   = raw_i[W-1] ^ tc_i;
  end

  assign word_o[0] = fmt[0];

  for (genvar b = 1; b < W; b++) begin : g_scr
    assign word_o[b] = fmt[b] ^ (scr_i & fmt[0]);
  end

endmodule

// File: rtl/adc_fmt_outreg.sv
module adc_fmt_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         rise_i,
  input  logic [W-1:0] word_i,
  input  logic         ovf_i,
  input  logic         stab_i,
  output logic [W-1:0] dout_o,
  output logic         ovf_o,
  output logic         stab_o,
  output logic         ck_p_o,
  output logic         ck_n_o
);
  logic [W-1:0] dout_q, dout_d;
  logic         ovf_q, ovf_d, stab_q, stab_d, ckp_q, ckp_d, ckn_q, ckn_d;

  always_comb begin
    dout_d = dout_q;
    ovf_d  = ovf_q;
    stab_d = stab_q;
    ckp_d  = ckp_q;
    if (load_i) begin
      dout_d = word_i;
      ovf_d  = ovf_i;
      stab_d = stab_i;
      ckp_d  = 1'b0;
    end else if (rise_i) begin
      ckp_d  = 1'b1;
    end
    ckn_d = ~ckp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      ovf_q  <= 1'b0;
      stab_q <= 1'b0;
      ckp_q  <= 1'b1;
      ckn_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      ovf_q  <= ovf_d;
      stab_q <= stab_d;
      ckp_q  <= ckp_d;
      ckn_q  <= ckn_d;
    end
  end

  assign dout_o = dout_q;
  assign ovf_o  = ovf_q;
  assign stab_o = stab_q;
  assign ck_p_o = ckp_q;
  assign ck_n_o = ckn_q;

  p_clk_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ck_p_o != ck_n_o);
  p_rise_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i && !load_i |=> ck_p_o);

endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt #(
  parameter int W   = 16,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_code,
  input  logic         over_rng,
  input  logic         under_rng,
  input  logic [1:0]   mode_lvl,
  input  logic         scramble_en,
  output logic [W-1:0] dout,
  output logic         ovf,
  output logic         dcs_en,
  output logic         clk_out_p,
  output logic         clk_out_n
);
  import adc_fmt_pkg::*;

  logic         ld, rs;
  logic [W-1:0] word;

  adc_fmt_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .load_o(ld), .rise_o(rs)
  );

  adc_fmt_encode #(.W(W)) u_enc (
    .raw_i(raw_code), .tc_i(mode_is_tc(mode_lvl)), .scr_i(scramble_en),
    .word_o(word)
  );

  adc_fmt_outreg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .rise_i(rs), .word_i(word),
    .ovf_i(over_rng | under_rng), .stab_i(mode_stab(mode_lvl)),
    .dout_o(dout), .ovf_o(ovf), .stab_o(dcs_en),
    .ck_p_o(clk_out_p), .ck_n_o(clk_out_n)
  );

  p_lsb_thru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> dout[0] == $past(raw_code[0]));
  p_ovf_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> ovf == $past(over_rng | under_rng));
  p_stab_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> dcs_en == ($past(mode_lvl) == 2'd1 || $past(mode_lvl) == 2'd2));
  p_msb_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld && !scramble_en |=> dout[W-1] == ($past(raw_code[W-1]) ^ $past(mode_lvl[1])));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(dout) && $stable(ovf) && $stable(dcs_en));
  p_fall_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $fell(clk_out_p));

endmodule

// File: tb/test_adc_word_fmt.sv
`timescale 1ns/1ps
module test_adc_word_fmt;
  localparam int W = 16;
  localparam int DIV = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] raw_code;
  logic         over_rng, under_rng, scramble_en;
  logic [1:0]   mode_lvl;
  logic [W-1:0] dout;
  logic         ovf, dcs_en, clk_out_p, clk_out_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 0, cmp_on = 0;

  always #4 clk = ~clk;

  adc_word_fmt #(.W(W), .DIV(DIV)) i_adc_word_fmt (
    .clk(clk), .rst_n(rst_n), .raw_code(raw_code), .over_rng(over_rng),
    .under_rng(under_rng), .mode_lvl(mode_lvl), .scramble_en(scramble_en),
    .dout(dout), .ovf(ovf), .dcs_en(dcs_en),
    .clk_out_p(clk_out_p), .clk_out_n(clk_out_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: integer counter since reset, arithmetic formatting
  int unsigned m_cnt;
  int unsigned e_d;
  int e_o, e_s, e_p;

  function automatic int unsigned ref_word(int unsigned r, int lvl, bit scr);
    int unsigned v = r;
    if (lvl >= 2) v = (v + 32'h8000) % 32'h10000;
    if (scr && (v % 2 == 1)) v = v ^ 32'hFFFE;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; e_d = 0; e_o = 0; e_s = 0; e_p = 1;
    end else begin
      m_cnt++;
      if (m_cnt % DIV == 0) begin
        e_d = ref_word(raw_code, mode_lvl, scramble_en);
        e_o = (over_rng || under_rng) ? 1 : 0;
        e_s = (mode_lvl == 1 || mode_lvl == 2) ? 1 : 0;
        e_p = 0;
      end else if (m_cnt % DIV == DIV / 2) begin
        e_p = 1;
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk(dout == e_d[W-1:0], "R1 R2 R4 R8 dout", dout, e_d);
    chk(dout[0] == e_d[0], "R5 lsb", dout[0], e_d[0]);
    chk(ovf == e_o[0], "R6 ovf", ovf, e_o);
    chk(dcs_en == e_s[0], "R3 dcs_en", dcs_en, e_s);
    chk(clk_out_p == e_p[0], "R7 R10 clk_out_p", clk_out_p, e_p);
    chk(clk_out_n == !e_p[0], "R7 clk_out_n", clk_out_n, !e_p[0]);
  end

  task automatic hold_word(input logic [W-1:0] r, input logic [1:0] m,
                           input bit s, input bit ov, input bit un);
    @(negedge clk);
    raw_code = r; mode_lvl = m; scramble_en = s; over_rng = ov; under_rng = un;
    repeat (2 * DIV) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; raw_code = '0; over_rng = 0; under_rng = 0;
    mode_lvl = 2'd3; scramble_en = 1;
    repeat (3) @(negedge clk);
    // R9: reset values at the ports
    chk(dout == 0 && ovf == 0 && dcs_en == 0, "R9 data reset", {ovf, dcs_en, dout}, 0);
    chk(clk_out_p == 1 && clk_out_n == 0, "R9 clock reset", {clk_out_p, clk_out_n}, 2);
    rst_n = 1'b1;
    raw_code = 16'hABCD; mode_lvl = 2'd0; scramble_en = 0;
    cmp_on = 1;
    // R10: first word on the DIV-th edge after release
    repeat (DIV - 1) @(negedge clk);
    chk(dout == 0, "R10 no early word", dout, 0);
    @(negedge clk);
    chk(dout == 16'hABCD, "R10 first word", dout, 16'hABCD);

    hold_word(16'h1234, 2'd0, 0, 0, 0);
    chk(dout == 16'h1234, "R1 offset binary", dout, 16'h1234);
    hold_word(16'h8000, 2'd2, 0, 1, 0);
    chk(dout == 16'h0000, "R2 mid-scale to zero", dout, 0);
    chk(ovf == 1, "R6 over-range", ovf, 1);
    hold_word(16'h7FFF, 2'd3, 0, 0, 1);
    chk(dout == 16'hFFFF, "R2 two's complement", dout, 16'hFFFF);
    chk(ovf == 1, "R6 under-range", ovf, 1);
    hold_word(16'h0001, 2'd3, 1, 0, 0);
    chk(dout == 16'h7FFF, "R4 scramble after format", dout, 16'h7FFF);
    hold_word(16'hFFFF, 2'd1, 1, 1, 1);
    chk(dout == 16'h0001, "R4 R5 scramble lsb kept", dout, 16'h0001);
    chk(dcs_en == 1, "R3 level 1 stabilizer", dcs_en, 1);
    hold_word(16'h5AA4, 2'd1, 1, 0, 0);
    chk(dout == 16'h5AA4, "R4 lsb zero no change", dout, 16'h5AA4);

    // R8: inputs changed every cycle, model catches mid-word changes
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      raw_code = W'($urandom); mode_lvl = 2'($urandom);
      scramble_en = 1'($urandom); over_rng = ($urandom % 8) == 0;
      under_rng = ($urandom % 8) == 0;
    end
    @(negedge clk);
    cmp_on = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule